// File: doc/BRIEF.md
# Reconfigurable Array Tile: Routing Switch with Four-Lane SIMD Unit

This block is one tile of a coarse-grained reconfigurable array. It has a routing switch and a small SIMD functional unit. The switch takes six 64-bit input buses and drives eight 64-bit output buses. Each output has its own 3-bit select. The first four switch outputs also serve as the candidate operands of the functional unit. The unit treats each 64-bit word as four 16-bit lanes. It can run lane-wise addition, lane-wise multiplication, a four-to-one reduction into a running accumulator, or a hard sigmoid on signed Q8.8 values. A predicate bit decides whether the sigmoid is applied or the operand passes through unchanged.

The tile is programmed serially. While `cfgMode` is high, one byte on `cfgData` is shifted in on every clock. The last five bytes form the 40-bit configuration word. When `cfgMode` drops, the tile runs with that word. A valid operation presented on `inValid` produces a registered result one cycle later.

Top module: `cgra_tile`

## Requirements
- R1: Each switch output k carries the input bus whose index equals its 3-bit select `route[k]`, for selects 0 to 5. The path from input to output is combinational.
- R2: A switch output whose select is 6 or 7 is all zeros.
- R3: While `cfgMode` is high, the configuration word shifts left by one byte on every clock, with `cfgData` entering bits [7:0]. Bytes sent before the last five are lost. The word does not change while `cfgMode` is low. Word layout: bits [3k+2:3k] hold `route[k]`; [25:24] hold the select for operand A; [27:26] hold the select for operand B; [29:28] hold the opcode (0 add, 1 multiply, 2 reduce, 3 sigmoid); [30] holds the predicate; [32:31] hold the result direction.
- R4: In add mode, every 16-bit lane of the result is A plus B for that lane, wrapping modulo 2^16.
- R5: In multiply mode, every lane of the result is the low 16 bits of A times B for that lane.
- R6: In reduce mode, the four lanes of A are summed and added to the accumulator. The new accumulator value appears in lane 0 and the other lanes are zero. All sums wrap modulo 2^16.
- R7: The accumulator clears on the first clock of configuration mode and when `accClear` is high. If `accClear` arrives together with a reduce operation, the accumulator takes that operation's lane sum alone.
- R8: In sigmoid mode with the predicate set, each lane x (signed Q8.8) becomes 0x0100 when x >= 0x0200, becomes 0 when x <= -0x0200, and otherwise becomes 0x0080 + (x >>> 2).
- R9: In sigmoid mode with the predicate clear, operand A passes through unchanged.
- R10: Operand A is switch output `selA` and operand B is switch output `selB`, each chosen from outputs 0 to 3.
- R11: `outValid` is high exactly one cycle after a cycle with `inValid` high and `cfgMode` low. A result is only captured in such a cycle: `inValid` during configuration mode is ignored, and `fuOut` holds its value otherwise.
- R12: `fuDir` is the one-hot decode of the 2-bit direction field.
- R13: After reset, the configuration word, the accumulator, `fuOut` and `outValid` are zero, so `fuDir` is 4'b0001.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgMode | input | 1 | High while configuration bytes are streamed in |
| cfgData | input | 8 | Configuration byte shifted in each cycle of configuration mode |
| inValid | input | 1 | Requests one functional-unit operation this cycle |
| accClear | input | 1 | Clears the reduction accumulator |
| inData | input | 384 | Six 64-bit switch input buses; bus i occupies bits [64i+63:64i] |
| routeOut | output | 512 | Eight 64-bit switch output buses; bus k occupies bits [64k+63:64k] |
| fuOut | output | 64 | Registered functional-unit result, lane 0 in bits [15:0] |
| outValid | output | 1 | `fuOut` holds a fresh result |
| fuDir | output | 4 | One-hot result direction |

## Verification
Two situations are hard to reach from the ports. The first is a clear that arrives in the same cycle as a reduce operation. The second is a configuration window during which operation requests keep arriving. Neither happens with ordinary stimulus. The bench raises `accClear` on the same falling edge as `inValid` and checks that the accumulator restarts from that operation's lane sum, not from zero and not from the old total. It also holds `inValid` high through a six-byte configuration load that starts with a junk byte. This confirms that no result is captured during the load, that only the final five bytes take effect, and that the accumulator was wiped on entry.

// File: rtl/cgra_tile_pkg.sv
package cgra_tile_pkg;
  parameter int LANE_W     = 16;
  parameter int LANES      = 4;
  parameter int DATA_W     = LANE_W * LANES;
  parameter int NUM_IN     = 6;
  parameter int NUM_OUT    = 8;
  parameter int SEL_W      = $clog2(NUM_OUT);
  parameter int FU_CANDS   = 4;
  parameter int OPSEL_W    = $clog2(FU_CANDS);
  parameter int CFG_BYTE_W = 8;
  parameter int CFG_BEATS  = 5;
  parameter int CFG_W      = CFG_BYTE_W * CFG_BEATS;
  parameter int DIR_W      = 2;
  parameter int DIR_OH_W   = 1 << DIR_W;
  parameter int OP_W       = 2;
  parameter int SPARE_W    = CFG_W - DIR_W - 1 - OP_W - 2 * OPSEL_W - NUM_OUT * SEL_W;
  parameter int SIG_FRAC   = LANE_W / 2;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 2'd0,
    OP_MUL = 2'd1,
    OP_RED = 2'd2,
    OP_SIG = 2'd3
  } fuOp_e;

  // Fields are listed from the most significant bit down.
  typedef struct packed {
    logic [SPARE_W-1:0]                spare;
    logic [DIR_W-1:0]                  dir;
    logic                              pred;
    fuOp_e                             op;
    logic [OPSEL_W-1:0]                selB;
    logic [OPSEL_W-1:0]                selA;
    logic [NUM_OUT-1:0][SEL_W-1:0]     route;
  } tileCfg_t;

  typedef struct packed {
    logic issue;   // accept an operation this cycle
    logic accClr;  // restart the accumulator
    logic accEn;   // reduce operation updates the accumulator
  } tileStrobe_t;
endpackage

// File: rtl/cgra_tile_ctrl.sv
module cgra_tile_ctrl
  import cgra_tile_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cfgMode,
  input  logic [CFG_BYTE_W-1:0] cfgData,
  input  logic                  inValid,
  input  logic                  accClear,
  output tileCfg_t              cfg,
  output tileStrobe_t           strobe
);
  logic [CFG_W-1:0] shiftQ;
  logic             cfgModeQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftQ   <= '0;
      cfgModeQ <= 1'b0;
    end else begin
      cfgModeQ <= cfgMode;
      if (cfgMode) begin
        shiftQ <= {shiftQ[CFG_W-CFG_BYTE_W-1:0], cfgData};
      end
    end
  end

  assign cfg = tileCfg_t'(shiftQ);

  always_comb begin
    strobe.issue  = inValid && !cfgMode;
    strobe.accClr = accClear || (cfgMode && !cfgModeQ);
    strobe.accEn  = strobe.issue && (cfg.op == OP_RED);
  end
endmodule

// File: rtl/cgra_tile_switch.sv
module cgra_tile_switch
  import cgra_tile_pkg::*;
(
  input  logic [NUM_IN*DATA_W-1:0]       inData,
  input  logic [NUM_OUT-1:0][SEL_W-1:0]  route,
  output logic [NUM_OUT*DATA_W-1:0]      routeOut
);
  for (genvar k = 0; k < NUM_OUT; k++) begin : g_out
    always_comb begin
      routeOut[k*DATA_W +: DATA_W] = '0;
      for (int s = 0; s < NUM_IN; s++) begin
        if (route[k] == SEL_W'(s)) begin
          routeOut[k*DATA_W +: DATA_W] = inData[s*DATA_W +: DATA_W];
        end
      end
    end
  end
endmodule

// File: rtl/cgra_tile_datapath.sv
module cgra_tile_datapath
  import cgra_tile_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_IN*DATA_W-1:0]  inData,
  input  tileCfg_t                  cfg,
  input  tileStrobe_t               strobe,
  output logic [NUM_OUT*DATA_W-1:0] routeOut,
  output logic [DATA_W-1:0]         fuOut,
  output logic                      outValid,
  output logic [DIR_OH_W-1:0]       fuDir,
  output logic [LANE_W-1:0]         accVal
);
  localparam logic [LANE_W-1:0]        SIG_ONE  = LANE_W'(1) << SIG_FRAC;
  localparam logic [LANE_W-1:0]        SIG_HALF = LANE_W'(1) << (SIG_FRAC - 1);
  localparam logic signed [LANE_W-1:0] SIG_HI   = LANE_W'(1) << (SIG_FRAC + 1);
  localparam logic signed [LANE_W-1:0] SIG_LO   = -SIG_HI;

  logic [FU_CANDS-1:0][DATA_W-1:0] cand;
  logic [DATA_W-1:0]               opA, opB;
  logic [LANES-1:0][LANE_W-1:0]    addRes, mulRes, sigRes;
  logic [LANE_W-1:0]               redSum, accNext, accQ;
  logic [DATA_W-1:0]               result;

  cgra_tile_switch u_switch (
    .inData   (inData),
    .route    (cfg.route),
    .routeOut (routeOut)
  );

  for (genvar c = 0; c < FU_CANDS; c++) begin : g_cand
    assign cand[c] = routeOut[c*DATA_W +: DATA_W];
  end

  assign opA = cand[cfg.selA];
  assign opB = cand[cfg.selB];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0]        aL, bL;
    logic signed [LANE_W-1:0] xs;
    assign aL = opA[l*LANE_W +: LANE_W];
    assign bL = opB[l*LANE_W +: LANE_W];
    assign xs = signed'(aL);
    assign addRes[l] = aL + bL;
    assign mulRes[l] = aL * bL;
    assign sigRes[l] = !cfg.pred     ? aL :
                       (xs >= SIG_HI) ? SIG_ONE :
                       (xs <= SIG_LO) ? '0 :
                       SIG_HALF + LANE_W'(xs >>> 2);
  end

  always_comb begin
    redSum = '0;
    for (int l = 0; l < LANES; l++) begin
      redSum = redSum + opA[l*LANE_W +: LANE_W];
    end
    accNext = (strobe.accClr ? '0 : accQ) + redSum;
  end

  always_comb begin
    unique case (cfg.op)
      OP_ADD:  result = addRes;
      OP_MUL:  result = mulRes;
      OP_RED:  result = DATA_W'(accNext);
      default: result = sigRes;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accQ     <= '0;
      fuOut    <= '0;
      outValid <= 1'b0;
    end else begin
      if (strobe.accEn) begin
        accQ <= accNext;
      end else if (strobe.accClr) begin
        accQ <= '0;
      end
      outValid <= strobe.issue;
      if (strobe.issue) begin
        fuOut <= result;
      end
    end
  end

  assign fuDir  = DIR_OH_W'(1) << cfg.dir;
  assign accVal = accQ;
endmodule

// File: rtl/cgra_tile.sv
module cgra_tile
  import cgra_tile_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      cfgMode,
  input  logic [CFG_BYTE_W-1:0]     cfgData,
  input  logic                      inValid,
  input  logic                      accClear,
  input  logic [NUM_IN*DATA_W-1:0]  inData,
  output logic [NUM_OUT*DATA_W-1:0] routeOut,
  output logic [DATA_W-1:0]         fuOut,
  output logic                      outValid,
  output logic [DIR_OH_W-1:0]       fuDir
);
  tileCfg_t          cfg;
  tileStrobe_t       strobe;
  logic [LANE_W-1:0] accVal;

  cgra_tile_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cfgMode  (cfgMode),
    .cfgData  (cfgData),
    .inValid  (inValid),
    .accClear (accClear),
    .cfg      (cfg),
    .strobe   (strobe)
  );

  cgra_tile_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .inData   (inData),
    .cfg      (cfg),
    .strobe   (strobe),
    .routeOut (routeOut),
    .fuOut    (fuOut),
    .outValid (outValid),
    .fuDir    (fuDir),
    .accVal   (accVal)
  );
endmodule

// File: rtl/cgra_tile_checker.sv
module cgra_tile_checker
  import cgra_tile_pkg::*;
(
  input logic                      clk,
  input logic                      rstN,
  input logic                      cfgMode,
  input logic                      inValid,
  input logic                      accClear,
  input logic [NUM_OUT*DATA_W-1:0] routeOut,
  input logic [DATA_W-1:0]         fuOut,
  input logic                      outValid,
  input tileCfg_t                  cfg,
  input logic [LANE_W-1:0]         accVal
);
  localparam logic [LANE_W-1:0] ONE_Q = LANE_W'(1) << SIG_FRAC;

  p_issue_valid_r11: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !cfgMode) |=> outValid);

  p_idle_novalid_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(inValid && !cfgMode) |=> !outValid);

  p_hold_result_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(inValid && !cfgMode) |=> $stable(fuOut));

  p_cfg_frozen_r3: assert property (@(posedge clk) disable iff (!rstN)
    !cfgMode |=> $stable(cfg));

  p_enter_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cfgMode) |=> (accVal == '0));

  p_explicit_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    (accClear && !(inValid && !cfgMode && cfg.op == OP_RED)) |=> (accVal == '0));

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_zero
    p_zero_route_r2: assert property (@(posedge clk) disable iff (!rstN)
      (int'(cfg.route[k]) >= NUM_IN) |-> (routeOut[k*DATA_W +: DATA_W] == '0));
  end

  for (genvar l = 0; l < LANES; l++) begin : g_sig
    p_sig_range_r8: assert property (@(posedge clk) disable iff (!rstN)
      (outValid && cfg.op == OP_SIG && cfg.pred) |-> (fuOut[l*LANE_W +: LANE_W] <= ONE_Q));
  end
endmodule

bind cgra_tile cgra_tile_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .cfgMode  (cfgMode),
  .inValid  (inValid),
  .accClear (accClear),
  .routeOut (routeOut),
  .fuOut    (fuOut),
  .outValid (outValid),
  .cfg      (cfg),
  .accVal   (accVal)
);

// File: tb/cgra_tile_bench.sv
module cgra_tile_bench;
  localparam int CLK_PERIOD = 10;
  localparam int VEC_N = 6;
  localparam logic [23:0] ID_ROUTE = {3'd7, 3'd6, 3'd5, 3'd4, 3'd3, 3'd2, 3'd1, 3'd0};

  // {op, pred, operand A, operand B, expected result}
  localparam logic [194:0] VEC [VEC_N] = '{
    {2'd0, 1'b0, 64'h0003_0003_0002_0001, 64'h0002_0030_0020_0010, 64'h0005_0033_0022_0011},
    {2'd0, 1'b0, 64'h7FFF_8000_1234_FFFF, 64'h0001_8000_1111_0002, 64'h8000_0000_2345_0001},
    {2'd1, 1'b0, 64'h0003_0100_FFFF_0010, 64'h0005_0100_0002_0010, 64'h000F_0000_FFFE_0100},
    {2'd3, 1'b1, 64'h0000_0200_FE00_0100, 64'h0,                   64'h0080_0100_0000_00C0},
    {2'd3, 1'b1, 64'h7FFF_8000_FF00_0004, 64'h0,                   64'h0100_0000_0040_0081},
    {2'd3, 1'b0, 64'h1234_5678_9ABC_DEF0, 64'h0,                   64'h1234_5678_9ABC_DEF0}
  };

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         cfgMode = 1'b0;
  logic [7:0]   cfgData = '0;
  logic         inValid = 1'b0;
  logic         accClear = 1'b0;
  logic [383:0] inData = '0;
  logic [511:0] routeOut;
  logic [63:0]  fuOut;
  logic         outValid;
  logic [3:0]   fuDir;

  int checks = 0;
  int failures = 0;

  cgra_tile u_cgra_tile (
    .clk      (clk),
    .rstN     (rstN),
    .cfgMode  (cfgMode),
    .cfgData  (cfgData),
    .inValid  (inValid),
    .accClear (accClear),
    .inData   (inData),
    .routeOut (routeOut),
    .fuOut    (fuOut),
    .outValid (outValid),
    .fuDir    (fuDir)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [39:0] mkCfg(input logic [23:0] rt, input logic [1:0] sa,
      input logic [1:0] sb, input logic [1:0] op, input logic pr, input logic [1:0] dir);
    return {7'd0, dir, pr, op, sb, sa, rt};
  endfunction

  task automatic loadCfg(input logic [39:0] w);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      cfgMode = 1'b1;
      cfgData = w[39-8*i -: 8];
    end
    @(negedge clk);
    cfgMode = 1'b0;
  endtask

  task automatic doIssue(input logic clr);
    @(negedge clk);
    inValid  = 1'b1;
    accClear = clr;
    @(negedge clk);
    inValid  = 1'b0;
    accClear = 1'b0;
  endtask

  task automatic setIn(input int idx, input logic [63:0] v);
    inData[idx*64 +: 64] = v;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [63:0] held;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R13: reset state
    chk("R13 fuOut", fuOut, 64'h0);
    chk("R13 outValid", {63'h0, outValid}, 64'h0);
    chk("R13 fuDir", {60'h0, fuDir}, 64'h1);
    chk("R13 routeOut", routeOut[63:0], 64'h0);

    // Vector table: R4 add, R5 multiply, R8 sigmoid, R9 bypass
    for (int v = 0; v < VEC_N; v++) begin
      logic [1:0] op;
      logic       pr;
      string      req;
      op = VEC[v][194:193];
      pr = VEC[v][192];
      loadCfg(mkCfg(ID_ROUTE, 2'd0, 2'd1, op, pr, 2'd0));
      setIn(0, VEC[v][191:128]);
      setIn(1, VEC[v][127:64]);
      doIssue(1'b0);
      req = (op == 2'd0) ? "R4" : (op == 2'd1) ? "R5" : pr ? "R8" : "R9";
      chk(req, fuOut, VEC[v][63:0]);
      chk("R11 valid", {63'h0, outValid}, 64'h1);
      held = fuOut;
      @(negedge clk);
      chk("R11 drop", {63'h0, outValid}, 64'h0);
      chk("R11 hold", fuOut, held);
    end

    // R6 / R7 reduction and accumulator clears
    loadCfg(mkCfg(ID_ROUTE, 2'd0, 2'd1, 2'd2, 1'b0, 2'd0));
    setIn(0, 64'h0001_0002_0003_0004);
    doIssue(1'b0);
    chk("R6 first", fuOut, 64'h000A);
    setIn(0, 64'h0010_0010_0010_0010);
    doIssue(1'b0);
    chk("R6 accumulate", fuOut, 64'h004A);
    setIn(0, 64'h0001_0001_0001_0001);
    doIssue(1'b1);
    chk("R7 clear with issue", fuOut, 64'h0004);
    @(negedge clk);
    accClear = 1'b1;
    @(negedge clk);
    accClear = 1'b0;
    doIssue(1'b0);
    chk("R7 clear alone", fuOut, 64'h0004);
    setIn(0, 64'hFFFF_FFFF_0000_0001);
    doIssue(1'b1);
    chk("R6 wrap", fuOut, 64'h0000_0000_0000_FFFF);
    // R3 / R7 / R11: six-byte load with junk first byte, inValid held high throughout
    held = fuOut;
    begin
      logic [39:0] w;
      w = mkCfg(ID_ROUTE, 2'd0, 2'd1, 2'd2, 1'b0, 2'd2);
      @(negedge clk);
      cfgMode = 1'b1;
      inValid = 1'b1;
      cfgData = 8'hA5;
      for (int i = 0; i < 5; i++) begin
        @(negedge clk);
        cfgData = w[39-8*i -: 8];
        chk("R11 ignored in cfg", {63'h0, outValid}, 64'h0);
      end
      @(negedge clk);
      cfgMode = 1'b0;
      inValid = 1'b0;
      chk("R11 no capture in cfg", fuOut, held);
    end
    chk("R12 dir", {60'h0, fuDir}, 64'h4);
    setIn(0, 64'h0001_0001_0001_0001);
    doIssue(1'b0);
    chk("R7 entry clear / R3 last five bytes", fuOut, 64'h0004);

    // R1 / R2 routing
    for (int i = 0; i < 6; i++) setIn(i, {4{16'(16'h1111 * (i + 1))}});
    loadCfg(mkCfg({3'd7, 3'd6, 3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5}, 2'd0, 2'd1, 2'd0, 1'b0, 2'd1));
    chk("R12 dir", {60'h0, fuDir}, 64'h2);
    for (int k = 0; k < 6; k++) begin
      chk("R1 route", routeOut[k*64 +: 64], {4{16'(16'h1111 * (6 - k))}});
    end
    chk("R2 sel6", routeOut[6*64 +: 64], 64'h0);
    chk("R2 sel7", routeOut[7*64 +: 64], 64'h0);

    // R10 operand select from outputs 2 and 3
    loadCfg(mkCfg({3'd7, 3'd6, 3'd0, 3'd1, 3'd5, 3'd4, 3'd1, 3'd0}, 2'd2, 2'd3, 2'd0, 1'b0, 2'd0));
    doIssue(1'b0);
    chk("R10 select", fuOut, {4{16'hBBBB}});
    loadCfg(mkCfg({3'd7, 3'd6, 3'd0, 3'd1, 3'd5, 3'd4, 3'd1, 3'd0}, 2'd3, 2'd0, 2'd1, 1'b0, 2'd0));
    doIssue(1'b0);
    chk("R10 select mul", fuOut, {4{16'(16'h6666 * 16'h1111)}});

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule